// File: doc/BRIEF.md
# Serial-Address Parallel SRAM Controller

This controller gives a host byte-wide access to an 8-bit asynchronous SRAM. The SRAM's address lines are not wired to the controller. They come from an external chain of serial-in, parallel-out registers. For each access the controller clocks a 24-bit address frame into that chain over a mode-0 serial clock and data pair. It then strobes a latch line so the chain presents the frame on its outputs. After that it runs the active-low read or write strobe on the shared 8-bit data bus. The bus is modelled as separate in, out and output-enable vectors.

The host holds a request (direction, 19-bit byte address, write byte) until it sees a one-cycle acknowledge. For a read, the data arrives with that acknowledge. The memory spans 512 KiB, so the five upper bits of every frame are zero.

A hand-off input lets another bus master use the memory. While hand-off is active, the controller leaves the read strobe low and the write strobe high. It also stops driving the data bus and disables the address chain's outputs.

Top module: `sram_serial_ctrl`

## Requirements
- R1: After reset, sram_rd_n and sram_wr_n are 1, dq_oe, addr_latch, ser_clk and req_ack are 0, and addr_drv_en is 1.
- R2: Each access shifts 24 bits, most significant bit first: bits 23..16, then 15..8, then 7..0. ser_data is valid at every rising edge of ser_clk. ser_clk idles low, and each of its high and low phases lasts CLK_HALF system clocks.
- R3: While address bits are being shifted or latched, sram_rd_n and sram_wr_n both stay 1.
- R4: Frame bits 23..19 are always 0, and bits 18..0 equal req_addr.
- R5: Exactly one addr_latch pulse occurs per access. It follows the 24th bit, starts only while ser_clk is low, lasts CLK_HALF clocks, and ends before either strobe falls.
- R6: A read keeps dq_oe at 0 and holds sram_rd_n low for exactly SETTLE clocks. rsp_rdata returns the value of dq_in in the last of those clocks.
- R7: A write raises dq_oe, carrying req_wdata on dq_out, one clock before sram_wr_n falls. sram_wr_n stays low for WR_PULSE clocks. dq_out holds steady throughout, and dq_oe stays high for one clock after sram_wr_n rises.
- R8: req_ack is high for exactly one clock per access. rsp_rdata is valid from that clock onward and is held.
- R9: sram_rd_n and sram_wr_n are never low together, and dq_oe is never high while sram_rd_n is low.
- R10: While handoff_en is high and no access is running, sram_rd_n is 0, sram_wr_n is 1, dq_oe is 0 and addr_drv_en is 0. An access already in progress completes before hand-off begins.
- R11: A request made during hand-off does not start (no serial clock, no latch, no acknowledge) until handoff_en falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Host request, held until req_ack |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 19 | Byte address |
| req_wdata | input | 8 | Write byte |
| req_ack | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 8 | Read byte, valid with req_ack |
| handoff_en | input | 1 | Release memory to an external master |
| ser_clk | output | 1 | Serial clock to address chain |
| ser_data | output | 1 | Serial address data |
| addr_latch | output | 1 | Transfer pulse for the address chain |
| addr_drv_en | output | 1 | Output enable of the address chain |
| sram_rd_n | output | 1 | Active-low read strobe |
| sram_wr_n | output | 1 | Active-low write strobe |
| dq_out | output | 8 | Data bus value driven on writes |
| dq_oe | output | 1 | Data bus drive enable |
| dq_in | input | 8 | Data bus value seen on reads |

## Verification
The assertions check several rules on every cycle. The strobes must stay idle while the serial engine is active, and the two strobes must never be low together. The bus must not be driven while a read is open. The latch must rise only with the serial clock low, and the acknowledge must be a single cycle. The hand-off pin levels and the absence of shifting during hand-off are also checked each cycle. Other properties need a bench model of the address chain and the memory, and only the bench scenarios can show them. These are the actual bit order and content of each frame, the read settle length and the returned byte, the write pulse width, and data surviving a hand-off that interrupts an access.

// File: rtl/sram_ser_pkg.sv
package sram_ser_pkg;

  localparam int FRAME_BITS = 24;
  localparam int DATA_BITS  = 8;

  typedef enum logic [1:0] {
    CTL_IDLE    = 2'd0,
    CTL_SHIFT   = 2'd1,
    CTL_ACCESS  = 2'd2,
    CTL_HANDOFF = 2'd3
  } ctl_state_e;

  // Width of a counter that must reach value 'lim'.
  function automatic int cnt_width(input int lim);
    return (lim < 2) ? 1 : $clog2(lim + 1);
  endfunction

  // True when a zero-based counter sits on the last cycle of a 'len'-cycle window.
  function automatic logic window_end(input int unsigned cnt, input int unsigned len);
    return cnt == (len - 1);
  endfunction

endpackage

// File: rtl/sram_addr_shifter.sv
module sram_addr_shifter
  import sram_ser_pkg::*;
#(
  parameter int CLK_HALF = 2,
  parameter int WORD_W   = FRAME_BITS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [WORD_W-1:0] word,
  output logic              sclk,
  output logic              sdo,
  output logic              latch,
  output logic              busy,
  output logic              done
);

  localparam int DIV_W = cnt_width(CLK_HALF);
  localparam int BIT_W = cnt_width(WORD_W);

  typedef enum logic [1:0] {SH_IDLE, SH_BITS, SH_LATCH} sh_state_e;

  sh_state_e         st;
  logic [WORD_W-1:0] shreg;
  logic [DIV_W-1:0]  div;
  logic [BIT_W-1:0]  bitn;
  logic              half_end;
  logic              last_bit;

  assign half_end = window_end(int'(div), CLK_HALF);
  assign last_bit = window_end(int'(bitn), WORD_W);
  assign sdo      = shreg[WORD_W-1];
  assign busy     = (st != SH_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= SH_IDLE;
      shreg <= '0;
      div   <= '0;
      bitn  <= '0;
      sclk  <= 1'b0;
      latch <= 1'b0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        SH_IDLE: begin
          if (start) begin
            shreg <= word;
            div   <= '0;
            bitn  <= '0;
            sclk  <= 1'b0;
            st    <= SH_BITS;
          end
        end
        SH_BITS: begin
          if (half_end) begin
            div <= '0;
            if (!sclk) begin
              sclk <= 1'b1;
            end else begin
              sclk <= 1'b0;
              if (last_bit) begin
                latch <= 1'b1;
                st    <= SH_LATCH;
              end else begin
                bitn  <= bitn + 1'b1;
                shreg <= shreg << 1;
              end
            end
          end else begin
            div <= div + 1'b1;
          end
        end
        SH_LATCH: begin
          if (half_end) begin
            div   <= '0;
            latch <= 1'b0;
            done  <= 1'b1;
            st    <= SH_IDLE;
          end else begin
            div <= div + 1'b1;
          end
        end
        default: st <= SH_IDLE;
      endcase
    end
  end

  assert_latch_sclk_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    latch |-> !sclk);

  assert_done_after_latch_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(latch) && !latch));

endmodule

// File: rtl/sram_strobe_seq.sv
module sram_strobe_seq
  import sram_ser_pkg::*;
#(
  parameter int SETTLE   = 8,
  parameter int WR_PULSE = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic                 is_write,
  input  logic [DATA_BITS-1:0] wdata,
  input  logic [DATA_BITS-1:0] dq_in,
  input  logic                 hold_rd,
  output logic                 rd_n,
  output logic                 wr_n,
  output logic                 dq_oe,
  output logic [DATA_BITS-1:0] dq_out,
  output logic [DATA_BITS-1:0] rdata,
  output logic                 done
);

  localparam int MAXC  = (SETTLE > WR_PULSE) ? SETTLE : WR_PULSE;
  localparam int CNT_W = cnt_width(MAXC);

  typedef enum logic [2:0] {Q_IDLE, Q_READ, Q_WSETUP, Q_WPULSE, Q_WHOLD} q_state_e;

  q_state_e         st;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= Q_IDLE;
      cnt    <= '0;
      rd_n   <= 1'b1;
      wr_n   <= 1'b1;
      dq_oe  <= 1'b0;
      dq_out <= '0;
      rdata  <= '0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        Q_IDLE: begin
          rd_n <= !hold_rd;
          if (start) begin
            cnt <= '0;
            if (is_write) begin
              dq_out <= wdata;
              dq_oe  <= 1'b1;
              rd_n   <= 1'b1;
              st     <= Q_WSETUP;
            end else begin
              rd_n <= 1'b0;
              st   <= Q_READ;
            end
          end
        end
        Q_READ: begin
          if (window_end(int'(cnt), SETTLE)) begin
            rdata <= dq_in;
            rd_n  <= 1'b1;
            done  <= 1'b1;
            st    <= Q_IDLE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        Q_WSETUP: begin
          wr_n <= 1'b0;
          cnt  <= '0;
          st   <= Q_WPULSE;
        end
        Q_WPULSE: begin
          if (window_end(int'(cnt), WR_PULSE)) begin
            wr_n <= 1'b1;
            st   <= Q_WHOLD;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        Q_WHOLD: begin
          dq_oe <= 1'b0;
          done  <= 1'b1;
          st    <= Q_IDLE;
        end
        default: st <= Q_IDLE;
      endcase
    end
  end

  assert_no_dual_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rd_n && !wr_n));

  assert_no_bus_fight_R9: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> rd_n);

  assert_wdata_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_n && !$past(wr_n)) |-> (dq_oe && $stable(dq_out)));

  assert_bus_before_wr_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wr_n) |-> $past(dq_oe));

endmodule

// File: rtl/sram_serial_ctrl.sv
module sram_serial_ctrl
  import sram_ser_pkg::*;
#(
  parameter int MEM_BYTES = 32'h80000,
  parameter int CLK_HALF  = 2,
  parameter int SETTLE    = 8,
  parameter int WR_PULSE  = 2,
  localparam int MEM_AW   = $clog2(MEM_BYTES)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  input  logic                 req_write,
  input  logic [MEM_AW-1:0]    req_addr,
  input  logic [DATA_BITS-1:0] req_wdata,
  output logic                 req_ack,
  output logic [DATA_BITS-1:0] rsp_rdata,
  input  logic                 handoff_en,
  output logic                 ser_clk,
  output logic                 ser_data,
  output logic                 addr_latch,
  output logic                 addr_drv_en,
  output logic                 sram_rd_n,
  output logic                 sram_wr_n,
  output logic [DATA_BITS-1:0] dq_out,
  output logic                 dq_oe,
  input  logic [DATA_BITS-1:0] dq_in
);

  localparam int PAD_W = FRAME_BITS - MEM_AW;

  ctl_state_e             state;
  logic                   op_write;
  logic [DATA_BITS-1:0]   wdata_q;
  logic [FRAME_BITS-1:0]  frame;
  logic                   sh_start;
  logic                   sh_busy;
  logic                   sh_done;
  logic                   seq_start;
  logic                   seq_done;
  logic                   in_handoff;

  generate
    if (PAD_W > 0) begin : g_pad
      assign frame = {{PAD_W{1'b0}}, req_addr};
    end else begin : g_nopad
      assign frame = req_addr[FRAME_BITS-1:0];
    end
  endgenerate

  assign sh_start    = (state == CTL_IDLE) && !handoff_en && req_valid;
  assign seq_start   = (state == CTL_SHIFT) && sh_done;
  assign in_handoff  = (state == CTL_HANDOFF);
  assign addr_drv_en = !in_handoff;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= CTL_IDLE;
      op_write <= 1'b0;
      wdata_q  <= '0;
      req_ack  <= 1'b0;
    end else begin
      req_ack <= 1'b0;
      case (state)
        CTL_IDLE: begin
          if (handoff_en) begin
            state <= CTL_HANDOFF;
          end else if (req_valid) begin
            op_write <= req_write;
            wdata_q  <= req_wdata;
            state    <= CTL_SHIFT;
          end
        end
        CTL_SHIFT:   if (sh_done) state <= CTL_ACCESS;
        CTL_ACCESS: begin
          if (seq_done) begin
            req_ack <= 1'b1;
            state   <= CTL_IDLE;
          end
        end
        CTL_HANDOFF: if (!handoff_en) state <= CTL_IDLE;
        default:     state <= CTL_IDLE;
      endcase
    end
  end

  sram_addr_shifter #(
    .CLK_HALF (CLK_HALF),
    .WORD_W   (FRAME_BITS)
  ) u_shift (
    .clk   (clk),
    .rst_n (rst_n),
    .start (sh_start),
    .word  (frame),
    .sclk  (ser_clk),
    .sdo   (ser_data),
    .latch (addr_latch),
    .busy  (sh_busy),
    .done  (sh_done)
  );

  sram_strobe_seq #(
    .SETTLE   (SETTLE),
    .WR_PULSE (WR_PULSE)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (seq_start),
    .is_write (op_write),
    .wdata    (wdata_q),
    .dq_in    (dq_in),
    .hold_rd  (in_handoff),
    .rd_n     (sram_rd_n),
    .wr_n     (sram_wr_n),
    .dq_oe    (dq_oe),
    .dq_out   (dq_out),
    .rdata    (rsp_rdata),
    .done     (seq_done)
  );

  assert_strobes_idle_shift_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sh_busy |-> (sram_rd_n && sram_wr_n));

  assert_ack_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    req_ack |=> !req_ack);

  assert_handoff_pins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_handoff && $past(in_handoff)) |-> (!sram_rd_n && sram_wr_n && !dq_oe && !addr_drv_en));

  assert_no_start_in_handoff_R11: assert property (@(posedge clk) disable iff (!rst_n)
    in_handoff |-> (!sh_busy && !ser_clk && !addr_latch && !req_ack));

endmodule

// File: tb/sram_serial_ctrl_bench.sv
`timescale 1ns/1ps
module sram_serial_ctrl_bench;

  localparam int HALF = 2;
  localparam int SETL = 8;
  localparam int WRP  = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [18:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        req_ack;
  logic [7:0]  rsp_rdata;
  logic        handoff_en = 1'b0;
  logic        ser_clk, ser_data, addr_latch, addr_drv_en;
  logic        sram_rd_n, sram_wr_n, dq_oe;
  logic [7:0]  dq_out;
  logic [7:0]  dq_in = 8'h00;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit done_flag = 0;

  always #4 clk = ~clk;

  sram_serial_ctrl #(
    .MEM_BYTES (32'h80000),
    .CLK_HALF  (HALF),
    .SETTLE    (SETL),
    .WR_PULSE  (WRP)
  ) u_sram_serial_ctrl (
    .clk (clk), .rst_n (rst_n),
    .req_valid (req_valid), .req_write (req_write), .req_addr (req_addr),
    .req_wdata (req_wdata), .req_ack (req_ack), .rsp_rdata (rsp_rdata),
    .handoff_en (handoff_en),
    .ser_clk (ser_clk), .ser_data (ser_data), .addr_latch (addr_latch),
    .addr_drv_en (addr_drv_en),
    .sram_rd_n (sram_rd_n), .sram_wr_n (sram_wr_n),
    .dq_out (dq_out), .dq_oe (dq_oe), .dq_in (dq_in)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at cycle %0d", req, act, exp, cycles);
    end
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  // ---- behavioural model of the address chain and the memory ----
  logic [7:0]  mem [int];
  logic [23:0] shift_cap = '0;
  logic [23:0] ext_addr = '0;
  logic [23:0] exp_addr = '0;
  logic [7:0]  exp_wdata = '0;
  int bitcnt = 0, run = 0, latch_pulses = 0, rd_low = 0, wr_low = 0;
  bit prev_sclk = 0, prev_latch = 0, prev_rd = 1, prev_wr = 1, prev_oe = 0;
  bit rd_is_access = 0;

  function automatic logic [7:0] mem_val(input logic [23:0] a);
    if (mem.exists(int'(a))) return mem[int'(a)];
    return a[7:0] ^ a[15:8] ^ 8'h3C;
  endfunction

  always @(negedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      chk(0, "watchdog", cycles, 150000);
      finish_run();
    end
    if (rst_n) begin
      // R9 every cycle
      chk(!(!sram_rd_n && !sram_wr_n), "R9 dual strobe", {sram_rd_n, sram_wr_n}, 3);
      chk(!(dq_oe && !sram_rd_n), "R9 bus fight", dq_oe, 0);
      // R3: strobes idle while clocking or latching
      if (ser_clk || addr_latch)
        chk(sram_rd_n && sram_wr_n, "R3 strobes during shift", {sram_rd_n, sram_wr_n}, 3);
      // R2: serial clock edges and phase lengths
      if (ser_clk != prev_sclk) begin
        if (!(ser_clk && bitcnt == 0)) chk(run == HALF, "R2 phase length", run, HALF);
        run = 1;
        if (ser_clk) begin
          shift_cap = {shift_cap[22:0], ser_data};
          bitcnt++;
        end
      end else begin
        run++;
      end
      // R5/R2/R4 at latch rise
      if (addr_latch && !prev_latch) begin
        latch_pulses++;
        chk(bitcnt == 24, "R5 bits before latch", bitcnt, 24);
        chk(!ser_clk, "R5 latch with clock low", ser_clk, 0);
        chk(shift_cap == exp_addr, "R2 frame content", shift_cap, exp_addr);
        chk(shift_cap[23:19] == 5'd0, "R4 upper bits zero", shift_cap[23:19], 0);
        ext_addr = shift_cap;
        bitcnt = 0;
      end
      // read strobe tracking
      if (!sram_rd_n && prev_rd) begin
        rd_is_access = addr_drv_en;
        rd_low = 0;
        chk(!addr_latch, "R5 latch ended before read", addr_latch, 0);
      end
      if (!sram_rd_n) rd_low++;
      if (sram_rd_n && !prev_rd && rd_is_access)
        chk(rd_low == SETL, "R6 read strobe width", rd_low, SETL);
      // write strobe tracking
      if (!sram_wr_n && prev_wr) begin
        wr_low = 0;
        chk(prev_oe, "R7 bus driven before wr", prev_oe, 1);
        chk(!addr_latch, "R5 latch ended before write", addr_latch, 0);
      end
      if (!sram_wr_n) begin
        wr_low++;
        chk(dq_oe && dq_out == exp_wdata, "R7 data during pulse", dq_out, exp_wdata);
      end
      if (sram_wr_n && !prev_wr) begin
        chk(wr_low == WRP, "R7 write pulse width", wr_low, WRP);
        chk(dq_oe, "R7 bus held after wr", dq_oe, 1);
        chk(ext_addr == exp_addr, "R4 write address", ext_addr, exp_addr);
        mem[int'(ext_addr)] = dq_out;
      end
      dq_in = sram_rd_n ? 8'h00 : mem_val(ext_addr);
      prev_sclk = ser_clk; prev_latch = addr_latch; prev_rd = sram_rd_n;
      prev_wr = sram_wr_n; prev_oe = dq_oe;
    end
  end

  task automatic start_op(input bit wr, input logic [18:0] a, input logic [7:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    exp_addr = {5'd0, a}; exp_wdata = d; latch_pulses = 0;
  endtask

  task automatic wait_ack(input bit wr, input logic [18:0] a);
    logic [7:0] exp_rd;
    exp_rd = mem_val({5'd0, a});
    do @(negedge clk); while (!req_ack);
    req_valid = 1'b0;
    chk(latch_pulses == 1, "R5 one latch per access", latch_pulses, 1);
    if (!wr) chk(rsp_rdata == exp_rd, "R6 read data", rsp_rdata, exp_rd);
    @(negedge clk);
    chk(!req_ack, "R8 ack single cycle", req_ack, 0);
    if (!wr) chk(rsp_rdata == exp_rd, "R8 read data held", rsp_rdata, exp_rd);
  endtask

  task automatic do_op(input bit wr, input logic [18:0] a, input logic [7:0] d);
    start_op(wr, a, d);
    wait_ack(wr, a);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(sram_rd_n && sram_wr_n && !dq_oe && !addr_latch && !ser_clk && !req_ack && addr_drv_en,
        "R1 reset state", {sram_rd_n, sram_wr_n, dq_oe, addr_latch, ser_clk, req_ack, addr_drv_en}, 7'b1100001);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(sram_rd_n && sram_wr_n && !dq_oe && addr_drv_en, "R1 idle after reset",
        {sram_rd_n, sram_wr_n, dq_oe, addr_drv_en}, 4'b1101);

    do_op(1'b1, 19'h00000, 8'hA5);
    do_op(1'b0, 19'h00000, 8'h00);
    do_op(1'b1, 19'h7FFFF, 8'h3C);
    do_op(1'b0, 19'h7FFFF, 8'h00);
    do_op(1'b1, 19'h12345, 8'h5A);
    do_op(1'b0, 19'h2A0F1, 8'h00);
    do_op(1'b0, 19'h12345, 8'h00);
    do_op(1'b1, 19'h55AA5, 8'hFF);
    do_op(1'b0, 19'h55AA5, 8'h00);

    // R10 idle hand-off
    @(negedge clk); handoff_en = 1'b1;
    repeat (3) @(negedge clk);
    chk(!sram_rd_n && sram_wr_n && !dq_oe && !addr_drv_en, "R10 hand-off pins",
        {sram_rd_n, sram_wr_n, dq_oe, addr_drv_en}, 4'b0100);
    // R11 request held off during hand-off
    start_op(1'b0, 19'h12345, 8'h00);
    begin
      bit seen = 0;
      for (int i = 0; i < 30; i++) begin
        @(negedge clk);
        if (req_ack || ser_clk || addr_latch) seen = 1;
      end
      chk(!seen, "R11 no activity in hand-off", seen, 0);
      chk(!sram_rd_n && !addr_drv_en, "R10 hand-off kept", {sram_rd_n, addr_drv_en}, 0);
    end
    handoff_en = 1'b0;
    wait_ack(1'b0, 19'h12345);

    // R10 hand-off requested mid-access: write completes first
    start_op(1'b1, 19'h00100, 8'hC3);
    repeat (10) @(negedge clk);
    handoff_en = 1'b1;
    wait_ack(1'b1, 19'h00100);
    repeat (3) @(negedge clk);
    chk(!sram_rd_n && sram_wr_n && !addr_drv_en, "R10 hand-off after access",
        {sram_rd_n, sram_wr_n, addr_drv_en}, 3'b010);
    handoff_en = 1'b0;
    repeat (2) @(negedge clk);
    chk(sram_rd_n && addr_drv_en, "R10 release restores idle", {sram_rd_n, addr_drv_en}, 3);
    chk(mem_val(24'h000100) == 8'hC3, "R7 interrupted write stored", mem_val(24'h000100), 8'hC3);
    do_op(1'b0, 19'h00100, 8'h00);

    repeat (5) @(negedge clk);
    finish_run();
  end

endmodule